// File: doc/BRIEF.md
# Source-Route Hop Port Selector

This block sits at the input side of a network-on-chip router in a network that uses source routing. The sender writes the whole path into the header's destination field. The path is a list of output-port indices, one for each router the flit will cross. The selector reads the slice that belongs to the current router and turns it into an output-port choice, given both as a binary index and as a one-hot vector. It then hands the header on with the route shifted, so that the next router finds its own slice at the bottom of the field.

Each router uses a slice of `ceil(log2(NUM_PORTS))` bits. The first hop occupies the least significant bits. The forwarded route is the incoming route shifted right by that many bits, with zeros filled in at the top. If the slice holds an index that names no existing port, an error flag is raised and no one-hot bit is set. The valid/ready handshake and the rest of the header pass through combinationally, without a register stage. The clock and the active-low synchronous reset serve only the embedded property checks.

Top module: `srhop_port_sel`

## Requirements
- R1: `port_idx` equals bits [HOP_W-1:0] of `in_route`, where HOP_W = ceil(log2(NUM_PORTS)) (3 with the default of 5 ports), in the same cycle.
- R2: When the slice value is below NUM_PORTS, `port_onehot` has exactly one bit set, at the position equal to the slice value.
- R3: `out_route` equals `in_route` shifted right by HOP_W bits, with the top HOP_W bits zero.
- R4: When the slice value is NUM_PORTS or greater (5, 6 or 7 by default), `port_err` is 1 and `port_onehot` is all zero. Otherwise `port_err` is 0.
- R5: `out_valid` follows `in_valid` and `in_ready` follows `out_ready` in the same cycle.
- R6: `out_payload` equals `in_payload` unchanged.
- R7: When each router's `out_route` is fed into the next selector, the bottom slices are consumed in order. A route that has been fully consumed reads as all zeros, which selects port 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only by the property checks |
| rst_n | input | 1 | Synchronous active-low reset for the property checks |
| in_valid | input | 1 | Upstream flit valid |
| in_ready | output | 1 | Ready returned upstream |
| in_route | input | ROUTE_W | Incoming route field, current hop in the low bits |
| in_payload | input | PAYLOAD_W | Rest of the header, carried through |
| out_valid | output | 1 | Flit valid towards the switch |
| out_ready | input | 1 | Ready from the switch |
| out_route | output | ROUTE_W | Route advanced by one hop |
| out_payload | output | PAYLOAD_W | Header remainder, unchanged |
| port_idx | output | IDX_W | Selected output port as a binary index |
| port_onehot | output | NUM_PORTS | Selected output port as a one-hot vector |
| port_err | output | 1 | Slice names a port that does not exist |

## Verification
The hardest case to reach from the ports is a multi-hop walk in which an illegal index appears only at a later hop. It stays hidden until the earlier slices have been shifted out. The bench builds such routes hop by hop and feeds each `out_route` back into `in_route`. It also sweeps every slice value, including all three out-of-range codes, and runs random headers against a behavioural model that uses division and modulo.

// File: rtl/srhop_pkg.sv
// Package srhop_pkg
// Purpose : width helpers shared by the hop port selector modules.
// Assumes : port counts are positive.
package srhop_pkg;

    // Bits a router with n output ports takes from the route.
    function automatic int hop_bits(input int n);
        return (n <= 1) ? 0 : $clog2(n);
    endfunction

    // Width of the binary port index; never narrower than one bit.
    function automatic int idx_bits(input int n);
        return (hop_bits(n) == 0) ? 1 : hop_bits(n);
    endfunction

endpackage

// File: rtl/srhop_extract.sv
// Module srhop_extract
// Purpose : takes the current hop's slice from the bottom of the route and
//           produces the route that remains for the next router.
// Assumes : ROUTE_W > HOP_W. The first hop sits in the least significant bits.
module srhop_extract #(
    parameter int ROUTE_W = 16,
    parameter int HOP_W   = 3,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ROUTE_W-1:0] route_in,
    output logic [IDX_W-1:0]   hop_idx,
    output logic [ROUTE_W-1:0] route_rest
);

    generate
        if (HOP_W == 0) begin : g_single
            // A single-port router consumes nothing.
            always_comb begin
                hop_idx    = '0;
                route_rest = route_in;
            end
        end else begin : g_slice
            // Read the bottom slice and shift the remainder down, filling with zeros.
            always_comb begin
                hop_idx    = route_in[HOP_W-1:0];
                route_rest = {{HOP_W{1'b0}}, route_in[ROUTE_W-1:HOP_W]};
            end

            // Slots vacated at the top hold zeros.
            assert_zero_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
                route_rest[ROUTE_W-1 -: HOP_W] == '0);
        end
    endgenerate

endmodule

// File: rtl/srhop_decode.sv
// Module srhop_decode
// Purpose : turns a binary port index into a one-hot select and flags an
//           index that names no existing port.
// Assumes : IDX_W is wide enough to hold NUM_PORTS-1.
module srhop_decode #(
    parameter int NUM_PORTS = 5,
    parameter int IDX_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IDX_W-1:0]     idx,
    output logic [NUM_PORTS-1:0] onehot,
    output logic                 err
);

    localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_PORTS);

    // Out-of-range detection, done one bit wider so a power-of-two count does not wrap.
    always_comb err = ({1'b0, idx} >= LIMIT);

    // One comparator per port; an out-of-range index matches none of them.
    always_comb begin
        onehot = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (idx == IDX_W'(p)) onehot[p] = 1'b1;
        end
    end

    assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !err |-> ($countones(onehot) == 1 && onehot[idx]));

    assert_err_no_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (onehot == '0));

    assert_onehot0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(onehot));

endmodule

// File: rtl/srhop_port_sel.sv
// Module srhop_port_sel
// Purpose : per-router stage of a source-routed network. It reads this hop's
//           port from the route, decodes it, and forwards the advanced route.
//           The handshake and the rest of the header pass through.
// Assumes : the route carries the first hop in its low bits. The clock and
//           reset drive only the embedded property checks.
module srhop_port_sel
    import srhop_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int ROUTE_W   = 16,
    parameter int PAYLOAD_W = 8,
    localparam int HOP_W    = hop_bits(NUM_PORTS),
    localparam int IDX_W    = idx_bits(NUM_PORTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [ROUTE_W-1:0]   in_route,
    input  logic [PAYLOAD_W-1:0] in_payload,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [ROUTE_W-1:0]   out_route,
    output logic [PAYLOAD_W-1:0] out_payload,
    output logic [IDX_W-1:0]     port_idx,
    output logic [NUM_PORTS-1:0] port_onehot,
    output logic                 port_err
);

    // Elaboration-time guard: the route must be wider than one hop's slice.
    initial begin
        if (ROUTE_W <= HOP_W) $error("route narrower than one hop slice");
    end

    logic [IDX_W-1:0] hop_idx;

    srhop_extract #(
        .ROUTE_W (ROUTE_W),
        .HOP_W   (HOP_W),
        .IDX_W   (IDX_W)
    ) u_extract (
        .clk        (clk),
        .rst_n      (rst_n),
        .route_in   (in_route),
        .hop_idx    (hop_idx),
        .route_rest (out_route)
    );

    srhop_decode #(
        .NUM_PORTS (NUM_PORTS),
        .IDX_W     (IDX_W)
    ) u_decode (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx    (hop_idx),
        .onehot (port_onehot),
        .err    (port_err)
    );

    // Pass the handshake and the header remainder through with no register stage.
    always_comb begin
        out_valid   = in_valid;
        in_ready    = out_ready;
        out_payload = in_payload;
        port_idx    = hop_idx;
    end

    generate
        if (HOP_W > 0) begin : g_chk
            // Slice and remainder together rebuild the incoming route.
            assert_rebuild_R3: assert property (@(posedge clk) disable iff (!rst_n)
                {out_route[ROUTE_W-HOP_W-1:0], port_idx[HOP_W-1:0]} == in_route);

            // A selected port always comes from a legal slice of the input route.
            assert_sel_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (port_onehot != '0) |-> (int'(in_route[HOP_W-1:0]) < NUM_PORTS));
        end
    endgenerate

endmodule

// File: tb/sim_srhop_port_sel.sv
`timescale 1ns/1ps
module sim_srhop_port_sel;

    localparam int NP = 5;
    localparam int RW = 16;
    localparam int PW = 8;
    localparam int HW = $clog2(NP);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0, out_ready = 1'b0;
    logic [RW-1:0] in_route = '0;
    logic [PW-1:0] in_payload = '0;
    logic          in_ready, out_valid, port_err;
    logic [RW-1:0] out_route;
    logic [PW-1:0] out_payload;
    logic [HW-1:0] port_idx;
    logic [NP-1:0] port_onehot;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    srhop_port_sel #(.NUM_PORTS(NP), .ROUTE_W(RW), .PAYLOAD_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_route(in_route), .in_payload(in_payload),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_route(out_route), .out_payload(out_payload),
        .port_idx(port_idx), .port_onehot(port_onehot), .port_err(port_err)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Behavioural reference: arithmetic on integers, compared with every output.
    task automatic compare_all();
        int r, slice, rest, oh;
        r     = int'(in_route);
        slice = r % (1 << HW);
        rest  = r / (1 << HW);
        oh    = (slice < NP) ? (1 << slice) : 0;
        check("R1 port_idx", port_idx, slice);
        check("R2 port_onehot", port_onehot, oh);
        check("R4 port_err", port_err, (slice >= NP) ? 1 : 0);
        check("R3 out_route", out_route, rest);
        check("R5 out_valid", out_valid, in_valid);
        check("R5 in_ready", in_ready, out_ready);
        check("R6 out_payload", out_payload, in_payload);
    endtask

    // Drive at the falling edge, then compare shortly afterwards.
    task automatic apply(input logic [RW-1:0] r, input logic [PW-1:0] p, input logic v, input logic rd);
        @(negedge clk);
        in_route = r; in_payload = p; in_valid = v; out_ready = rd;
        #1 compare_all();
    endtask

    initial begin
        // Reset state: all inputs zero.
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R5 reset out_valid", out_valid, 0);
        check("R7 reset port_onehot", port_onehot, 1);
        check("R4 reset port_err", port_err, 0);

        // Every slice value, including the out-of-range codes 5..7 (R4).
        for (int s = 0; s < (1 << HW); s++) begin
            apply(RW'(16'hA5A0 | s), PW'(s * 17), 1'b1, s[0]);
            check("R4 sweep err", port_err, (s >= NP) ? 1 : 0);
        end

        // An all-ones route: an illegal slice, and the top bits must fill with zeros (R3).
        apply('1, 8'hFF, 1'b1, 1'b1);
        check("R3 zero fill", out_route, 16'h1FFF);

        // Hop-by-hop walk, ports 2,4,0,3, then an illegal 6 at the fifth hop (R7).
        begin
            int hops[5] = '{2, 4, 0, 3, 6};
            logic [RW-1:0] r = '0;
            for (int h = 4; h >= 0; h--) r = (r << HW) | RW'(hops[h]);
            for (int h = 0; h < 5; h++) begin
                apply(r, 8'h3C, 1'b1, 1'b1);
                check("R7 walk idx", port_idx, hops[h]);
                check("R7 walk err", port_err, (hops[h] >= NP) ? 1 : 0);
                r = out_route;
            end
            apply(r, 8'h3C, 1'b1, 1'b1);
            check("R7 consumed route selects port 0", port_onehot, 1);
            check("R7 consumed route zero", out_route, 0);
        end

        // Random headers and handshakes.
        for (int i = 0; i < 400; i++)
            apply(RW'($urandom), PW'($urandom), 1'($urandom), 1'($urandom));

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule